// File: doc/BRIEF.md
# USB Device State and Status-Stage Tracker

This block holds the enumeration state of a USB device controller, which is one of Default, Addressed or Configured. It also watches endpoint-0 control reads so it can flag a host that moves to the status stage before the data phase has delivered all requested bytes. The packet engine sends it one-cycle event strobes: setup received (with the request direction and the requested length), bytes transmitted on endpoint 0, OUT token, address assigned, and bus reset. It also receives the code of the standard request now being handled. It returns whether that request is allowed in the present state.

Firmware reaches the block through a two-location register port. Location 0 holds the state field. Only the Configured bit can be written there, and each write sets or clears Addressed as a side effect. After each accepted write the location is locked for a recovery window. Location 1 holds the early-status interrupt enable and the sticky interrupt flag. Every setup packet disarms the enable, so firmware re-arms it for each control transfer in which it wants the interrupt.

Top module: `usb_devstate_tracker`

## Requirements
- R1: After reset the state reads Default (location 0 reads 8'h01), the interrupt enable and flag read 0, busy_o is 0 and irq_o is 0.
- R2: The state is one-hot: bit2 = Configured, bit1 = Addressed, bit0 = Default. Reading location 0 returns {5'b0, state}, and dev_state_o carries the same three bits.
- R3: An accepted write to location 0 with data bit2 = 1 enters Configured and clears Addressed. With bit2 = 0 it enters Addressed. Data bits 1 and 0 have no effect.
- R4: An accepted write to location 0 raises busy_o for RECOV_USB*USB_DIV cycles, starting the cycle after the write. Writes to location 0 while busy_o is 1 are ignored.
- R5: An address-assigned strobe moves Default to Addressed. It is ignored in the other states and yields to a same-cycle accepted write.
- R6: A bus reset strobe forces Default on the next cycle and takes priority over a same-cycle write or address strobe. It also closes any open control-read data phase.
- R7: Location 1 reads {6'b0, flag, enable}. A write sets the enable from data bit0. Writing 1 to data bit1 clears the flag. A setup strobe clears the enable, and this wins over a same-cycle write.
- R8: A setup strobe with the direction bit set to device-to-host and a nonzero length opens a data phase, with the byte count at 0. Each endpoint-0 transmit strobe during the open phase adds its byte count, capped at the requested length.
- R9: An OUT token during an open phase with count below the requested length and the enable set makes the flag 1 on the next cycle. A setup in the same cycle blocks this. Any OUT token closes the phase. The flag stays at 1 until cleared (setting wins over a same-cycle clear), and irq_o equals the flag.
- R10: req_ok_o is combinational on req_code_i. Codes 5 and 6 are allowed in every state. Codes 0, 1, 3, 7, 8 and 9 are allowed in Addressed and Configured. Codes 10, 11 and 12 are allowed only in Configured. Codes 2, 4, 13, 14 and 15 are never allowed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_reset_i | input | 1 | USB bus reset strobe |
| addr_set_i | input | 1 | Address-assigned strobe |
| cpu_wr_i | input | 1 | Register write strobe |
| cpu_addr_i | input | 1 | Register location: 0 state, 1 interrupt control |
| cpu_wdata_i | input | 3 | Write data (bits used by the two locations) |
| cpu_rdata_o | output | 8 | Read data for the addressed location |
| busy_o | output | 1 | State-write recovery window active |
| setup_i | input | 1 | Setup packet received strobe |
| setup_dir_in_i | input | 1 | Setup direction is device-to-host |
| wlength_i | input | WLEN_W | Requested length from the setup packet |
| ep0_tx_i | input | 1 | Endpoint-0 data packet sent strobe |
| ep0_tx_bytes_i | input | BYTES_W | Bytes in that packet |
| out_tok_i | input | 1 | OUT token on endpoint 0 |
| irq_o | output | 1 | Early status-stage interrupt |
| req_code_i | input | 4 | Standard request code being handled |
| req_ok_o | output | 1 | Request allowed in the present state |
| dev_state_o | output | 3 | One-hot device state |

## Verification
The bench builds the block with USB_DIV = 2, so the recovery window lasts ten cycles. Writes that land inside the window, at its last cycle and just after it are all reached many times over. WLEN_W = 8 and BYTES_W = 4 keep the requested lengths small, down to a few bytes. Short deliveries, exact deliveries and deliveries capped at the requested length then all occur within a few packets, and many times in the randomized run.

// File: rtl/usbst_pkg.sv
`timescale 1ns/1ps
package usbst_pkg;

  typedef enum logic [2:0] {
    ST_DEFAULT    = 3'b001,
    ST_ADDRESSED  = 3'b010,
    ST_CONFIGURED = 3'b100
  } dev_state_e;

  // Recovery window length in system clocks.
  function automatic int unsigned recov_cycles(int unsigned usb_div, int unsigned usb_cyc);
    return usb_div * usb_cyc;
  endfunction

  // Standard-request permission per device state.
  function automatic logic req_allowed(dev_state_e st, logic [3:0] code);
    logic any_state, post_addr, cfg_only;
    any_state = (code == 4'd5) || (code == 4'd6);
    post_addr = (code == 4'd0) || (code == 4'd1) || (code == 4'd3) ||
                (code == 4'd7) || (code == 4'd8) || (code == 4'd9);
    cfg_only  = (code == 4'd10) || (code == 4'd11) || (code == 4'd12);
    case (st)
      ST_DEFAULT:    return any_state;
      ST_ADDRESSED:  return any_state | post_addr;
      ST_CONFIGURED: return any_state | post_addr | cfg_only;
      default:       return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/usbst_recovery.sv
`timescale 1ns/1ps
module usbst_recovery #(
  parameter int unsigned CYCLES = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o
);
  localparam int unsigned CW = $clog2(CYCLES + 1);

  logic [CW-1:0] remain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                remain_q <= '0;
    else if (start_i)          remain_q <= CW'(CYCLES);
    else if (remain_q != '0)   remain_q <= remain_q - 1'b1;
  end

  assign busy_o = (remain_q != '0);
endmodule

// File: rtl/usbst_state_reg.sv
`timescale 1ns/1ps
module usbst_state_reg
  import usbst_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_reset_i,
  input  logic       wr_accept_i,
  input  logic       wr_cfg_i,
  input  logic       addr_set_i,
  output dev_state_e state_o
);
  dev_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (bus_reset_i)
      state_d = ST_DEFAULT;
    else if (wr_accept_i)
      state_d = wr_cfg_i ? ST_CONFIGURED : ST_ADDRESSED;
    else if (addr_set_i && state_q == ST_DEFAULT)
      state_d = ST_ADDRESSED;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_DEFAULT;
    else        state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/usbst_status_det.sv
`timescale 1ns/1ps
module usbst_status_det #(
  parameter int unsigned WLEN_W  = 16,
  parameter int unsigned BYTES_W = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               setup_i,
  input  logic               dir_in_i,
  input  logic [WLEN_W-1:0]  wlength_i,
  input  logic               tx_i,
  input  logic [BYTES_W-1:0] tx_bytes_i,
  input  logic               out_tok_i,
  input  logic               bus_reset_i,
  input  logic               en_wr_i,
  input  logic               en_wdata_i,
  input  logic               flag_clr_i,
  output logic               irq_en_o,
  output logic               flag_o,
  output logic               short_hit_o
);
  localparam int unsigned SW = WLEN_W + 1;

  logic              open_q, en_q, flag_q;
  logic [WLEN_W-1:0] sent_q, wlen_q;

  // Running byte total, never beyond the requested length.
  function automatic logic [WLEN_W-1:0] capped_add(logic [WLEN_W-1:0] cnt,
                                                   logic [BYTES_W-1:0] add,
                                                   logic [WLEN_W-1:0] cap);
    logic [SW-1:0] sum;
    sum = {1'b0, cnt} + SW'(add);
    return (sum > {1'b0, cap}) ? cap : sum[WLEN_W-1:0];
  endfunction

  assign short_hit_o = out_tok_i & ~setup_i & open_q & (sent_q < wlen_q) & en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      sent_q <= '0;
      wlen_q <= '0;
    end else if (setup_i) begin
      open_q <= dir_in_i & (|wlength_i);
      sent_q <= '0;
      wlen_q <= wlength_i;
    end else if (bus_reset_i) begin
      open_q <= 1'b0;
    end else begin
      if (tx_i && open_q) sent_q <= capped_add(sent_q, tx_bytes_i, wlen_q);
      if (out_tok_i)      open_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       en_q <= 1'b0;
    else if (setup_i) en_q <= 1'b0;
    else if (en_wr_i) en_q <= en_wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           flag_q <= 1'b0;
    else if (short_hit_o) flag_q <= 1'b1;
    else if (flag_clr_i)  flag_q <= 1'b0;
  end

  assign irq_en_o = en_q;
  assign flag_o   = flag_q;
endmodule

// File: rtl/usb_devstate_tracker.sv
`timescale 1ns/1ps
module usb_devstate_tracker
  import usbst_pkg::*;
#(
  parameter int unsigned USB_DIV   = 4,
  parameter int unsigned RECOV_USB = 5,
  parameter int unsigned WLEN_W    = 16,
  parameter int unsigned BYTES_W   = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_reset_i,
  input  logic               addr_set_i,
  input  logic               cpu_wr_i,
  input  logic               cpu_addr_i,
  input  logic [2:0]         cpu_wdata_i,
  output logic [7:0]         cpu_rdata_o,
  output logic               busy_o,
  input  logic               setup_i,
  input  logic               setup_dir_in_i,
  input  logic [WLEN_W-1:0]  wlength_i,
  input  logic               ep0_tx_i,
  input  logic [BYTES_W-1:0] ep0_tx_bytes_i,
  input  logic               out_tok_i,
  output logic               irq_o,
  input  logic [3:0]         req_code_i,
  output logic               req_ok_o,
  output logic [2:0]         dev_state_o
);
  localparam int unsigned RECOV = recov_cycles(USB_DIV, RECOV_USB);

  dev_state_e state;
  logic       wr_accept, ctl_wr, irq_en, flag, short_hit;

  assign wr_accept = cpu_wr_i & ~cpu_addr_i & ~busy_o;
  assign ctl_wr    = cpu_wr_i & cpu_addr_i;

  usbst_recovery #(.CYCLES(RECOV)) u_recov (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (wr_accept),
    .busy_o  (busy_o)
  );

  usbst_state_reg u_state (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_reset_i (bus_reset_i),
    .wr_accept_i (wr_accept),
    .wr_cfg_i    (cpu_wdata_i[2]),
    .addr_set_i  (addr_set_i),
    .state_o     (state)
  );

  usbst_status_det #(.WLEN_W(WLEN_W), .BYTES_W(BYTES_W)) u_det (
    .clk         (clk),
    .rst_n       (rst_n),
    .setup_i     (setup_i),
    .dir_in_i    (setup_dir_in_i),
    .wlength_i   (wlength_i),
    .tx_i        (ep0_tx_i),
    .tx_bytes_i  (ep0_tx_bytes_i),
    .out_tok_i   (out_tok_i),
    .bus_reset_i (bus_reset_i),
    .en_wr_i     (ctl_wr),
    .en_wdata_i  (cpu_wdata_i[0]),
    .flag_clr_i  (ctl_wr & cpu_wdata_i[1]),
    .irq_en_o    (irq_en),
    .flag_o      (flag),
    .short_hit_o (short_hit)
  );

  assign dev_state_o = state;
  assign irq_o       = flag;
  assign req_ok_o    = req_allowed(state, req_code_i);
  assign cpu_rdata_o = cpu_addr_i ? {6'b0, flag, irq_en} : {5'b0, state};
endmodule

// File: rtl/usbst_checker.sv
`timescale 1ns/1ps
module usbst_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_reset_i,
  input logic       addr_set_i,
  input logic       setup_i,
  input logic       cpu_wr_i,
  input logic       cpu_addr_i,
  input logic [2:0] cpu_wdata_i,
  input logic [2:0] dev_state_o,
  input logic       busy_o,
  input logic       irq_o,
  input logic       wr_accept,
  input logic       irq_en,
  input logic       short_hit
);
  a_r2_one_hot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(dev_state_o) == 1);

  a_r6_bus_reset_default: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset_i |=> dev_state_o == 3'b001);

  a_r3_cfg_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept && cpu_wdata_i[2] && !bus_reset_i |=> dev_state_o == 3'b100);

  a_r4_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |=> busy_o);

  a_r4_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr_i && !cpu_addr_i && busy_o && !bus_reset_i && !addr_set_i
      |=> $stable(dev_state_o));

  a_r7_setup_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    setup_i |=> !irq_en);

  a_r9_hit_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    short_hit |=> irq_o);

  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o && !(cpu_wr_i && cpu_addr_i && cpu_wdata_i[1]) |=> irq_o);
endmodule

bind usb_devstate_tracker usbst_checker u_usbst_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_reset_i (bus_reset_i),
  .addr_set_i  (addr_set_i),
  .setup_i     (setup_i),
  .cpu_wr_i    (cpu_wr_i),
  .cpu_addr_i  (cpu_addr_i),
  .cpu_wdata_i (cpu_wdata_i),
  .dev_state_o (dev_state_o),
  .busy_o      (busy_o),
  .irq_o       (irq_o),
  .wr_accept   (wr_accept),
  .irq_en      (irq_en),
  .short_hit   (short_hit)
);

// File: tb/test_usb_devstate_tracker.sv
`timescale 1ns/1ps
module test_usb_devstate_tracker;
  localparam int USB_DIV = 2;
  localparam int RECOV_USB = 5;
  localparam int WLEN_W = 8;
  localparam int BYTES_W = 4;
  localparam int WINDOW = USB_DIV * RECOV_USB;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_reset_i, addr_set_i, cpu_wr_i, cpu_addr_i;
  logic [2:0] cpu_wdata_i;
  logic [7:0] cpu_rdata_o;
  logic busy_o, setup_i, setup_dir_in_i, ep0_tx_i, out_tok_i, irq_o, req_ok_o;
  logic [WLEN_W-1:0] wlength_i;
  logic [BYTES_W-1:0] ep0_tx_bytes_i;
  logic [3:0] req_code_i;
  logic [2:0] dev_state_o;

  always #5 clk = ~clk;

  usb_devstate_tracker #(.USB_DIV(USB_DIV), .RECOV_USB(RECOV_USB),
                         .WLEN_W(WLEN_W), .BYTES_W(BYTES_W)) i_usb_devstate_tracker (
    .clk(clk), .rst_n(rst_n), .bus_reset_i(bus_reset_i), .addr_set_i(addr_set_i),
    .cpu_wr_i(cpu_wr_i), .cpu_addr_i(cpu_addr_i), .cpu_wdata_i(cpu_wdata_i),
    .cpu_rdata_o(cpu_rdata_o), .busy_o(busy_o), .setup_i(setup_i),
    .setup_dir_in_i(setup_dir_in_i), .wlength_i(wlength_i), .ep0_tx_i(ep0_tx_i),
    .ep0_tx_bytes_i(ep0_tx_bytes_i), .out_tok_i(out_tok_i), .irq_o(irq_o),
    .req_code_i(req_code_i), .req_ok_o(req_ok_o), .dev_state_o(dev_state_o));

  // Behavioural reference state
  int m_state = 1, m_busy = 0, m_en = 0, m_flag = 0, m_open = 0, m_cnt = 0, m_wlen = 0;
  int vectors = 0, miscompares = 0;
  bit done = 0;

  function automatic int ref_ok(int st, int code);
    case (code)
      5, 6:                return 1;
      0, 1, 3, 7, 8, 9:    return (st != 1) ? 1 : 0;
      10, 11, 12:          return (st == 4) ? 1 : 0;
      default:             return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 1; m_busy = 0; m_en = 0; m_flag = 0; m_open = 0; m_cnt = 0; m_wlen = 0;
    end else begin
      bit acc, hit;
      int n_state, n_en, n_open, n_cnt;
      acc = cpu_wr_i && !cpu_addr_i && (m_busy == 0);
      hit = out_tok_i && !setup_i && (m_open != 0) && (m_cnt < m_wlen) && (m_en != 0);
      n_state = m_state;
      if (bus_reset_i) n_state = 1;
      else if (acc) n_state = cpu_wdata_i[2] ? 4 : 2;
      else if (addr_set_i && m_state == 1) n_state = 2;
      n_en = m_en;
      if (setup_i) n_en = 0;
      else if (cpu_wr_i && cpu_addr_i) n_en = cpu_wdata_i[0];
      if (hit) m_flag = 1;
      else if (cpu_wr_i && cpu_addr_i && cpu_wdata_i[1]) m_flag = 0;
      n_open = m_open; n_cnt = m_cnt;
      if (setup_i) begin
        n_open = (setup_dir_in_i && wlength_i != 0) ? 1 : 0;
        n_cnt = 0; m_wlen = int'(wlength_i);
      end else if (bus_reset_i) n_open = 0;
      else begin
        if (ep0_tx_i && m_open != 0) begin
          n_cnt = m_cnt + int'(ep0_tx_bytes_i);
          if (n_cnt > m_wlen) n_cnt = m_wlen;
        end
        if (out_tok_i) n_open = 0;
      end
      m_busy = acc ? WINDOW : (m_busy > 0 ? m_busy - 1 : 0);
      m_state = n_state; m_en = n_en; m_open = n_open; m_cnt = n_cnt;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R3", "dev_state_o", int'(dev_state_o), m_state);
    chk("R4", "busy_o", int'(busy_o), (m_busy != 0) ? 1 : 0);
    chk("R9", "irq_o", int'(irq_o), m_flag);
    chk("R10", "req_ok_o", int'(req_ok_o), ref_ok(m_state, int'(req_code_i)));
    if (cpu_addr_i) chk("R7", "rdata loc1", int'(cpu_rdata_o), m_flag * 2 + m_en);
    else            chk("R2", "rdata loc0", int'(cpu_rdata_o), m_state);
  endtask

  task automatic idle();
    bus_reset_i = 0; addr_set_i = 0; cpu_wr_i = 0; cpu_addr_i = 0; cpu_wdata_i = 0;
    setup_i = 0; setup_dir_in_i = 0; wlength_i = 0; ep0_tx_i = 0; ep0_tx_bytes_i = 0;
    out_tok_i = 0; req_code_i = 0;
  endtask

  // Compare just before the edge, then move to the next falling edge.
  task automatic tick();
    #1 compare_all();
    @(negedge clk);
  endtask

  task automatic wr(bit loc, logic [2:0] d);
    idle(); cpu_wr_i = 1; cpu_addr_i = loc; cpu_wdata_i = d; tick();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset values at both locations
    #1;
    chk("R1", "loc0 after reset", int'(cpu_rdata_o), 1);
    chk("R1", "busy after reset", int'(busy_o), 0);
    chk("R1", "irq after reset", int'(irq_o), 0);
    cpu_addr_i = 1;
    #1 chk("R1", "loc1 after reset", int'(cpu_rdata_o), 0);
    @(negedge clk);

    // R10 sweep in Default
    for (int c = 0; c < 16; c++) begin idle(); req_code_i = 4'(c); tick(); end
    // R3: configure, R4: write in window ignored
    wr(0, 3'b100);
    idle(); tick(); idle(); tick();
    wr(0, 3'b011);
    for (int k = 0; k < WINDOW; k++) begin idle(); tick(); end
    for (int c = 0; c < 16; c++) begin idle(); req_code_i = 4'(c); tick(); end
    wr(0, 3'b000);
    for (int c = 0; c < 16; c++) begin idle(); req_code_i = 4'(c); tick(); end
    // R6: bus reset beats a same-cycle write
    for (int k = 0; k < WINDOW; k++) begin idle(); tick(); end
    idle(); bus_reset_i = 1; cpu_wr_i = 1; cpu_wdata_i = 3'b100; tick();
    // R5: address strobe from Default, then ignored in Addressed
    idle(); addr_set_i = 1; tick();
    idle(); addr_set_i = 1; tick();

    // R8/R9: short control read with enable re-armed after setup
    wr(1, 3'b001);
    idle(); setup_i = 1; setup_dir_in_i = 1; wlength_i = 20; cpu_addr_i = 1; tick();
    wr(1, 3'b001);
    idle(); ep0_tx_i = 1; ep0_tx_bytes_i = 8; tick();
    idle(); out_tok_i = 1; cpu_addr_i = 1; tick();
    idle(); cpu_addr_i = 1; tick();
    wr(1, 3'b011);  // R7: clear flag, keep enable
    // full delivery with cap: no interrupt
    idle(); setup_i = 1; setup_dir_in_i = 1; wlength_i = 20; tick();
    wr(1, 3'b001);
    idle(); ep0_tx_i = 1; ep0_tx_bytes_i = 15; tick();
    idle(); ep0_tx_i = 1; ep0_tx_bytes_i = 15; tick();
    idle(); out_tok_i = 1; cpu_addr_i = 1; tick();
    // enable left clear after setup: no interrupt
    idle(); setup_i = 1; setup_dir_in_i = 1; wlength_i = 9; tick();
    idle(); out_tok_i = 1; cpu_addr_i = 1; tick();

    // Randomized traffic
    for (int n = 0; n < 4000; n++) begin
      idle();
      bus_reset_i    = ($urandom_range(0, 63) == 0);
      addr_set_i     = ($urandom_range(0, 15) == 0);
      cpu_wr_i       = ($urandom_range(0, 5) == 0);
      cpu_addr_i     = 1'($urandom_range(0, 1));
      cpu_wdata_i    = 3'($urandom_range(0, 7));
      setup_i        = ($urandom_range(0, 11) == 0);
      setup_dir_in_i = ($urandom_range(0, 3) != 0);
      wlength_i      = WLEN_W'($urandom_range(0, 40));
      ep0_tx_i       = ($urandom_range(0, 2) == 0);
      ep0_tx_bytes_i = BYTES_W'($urandom_range(0, 15));
      out_tok_i      = ($urandom_range(0, 9) == 0);
      req_code_i     = 4'($urandom_range(0, 15));
      if (cpu_wr_i && cpu_addr_i && $urandom_range(0, 1) == 1) cpu_wdata_i[0] = 1'b1;
      tick();
    end
    finish_run();
  end
endmodule